// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a 4 KB direct-mapped data cache with a small, fully associative victim buffer beside it. The primary array keeps hit time short. When a line has to leave the primary array, it moves into the victim buffer and is not dropped. If an access misses in the primary array, the victim buffer is searched in the same cycle. When the line is found there, the two lines trade places and no memory transfer takes place. Lines that conflict for one slot therefore behave as if the cache had more ways.

The CPU side takes a word address with a read strobe or a write strobe and write data. It returns read data, a hit flag and a stall flag. While the stall flag is high, the CPU holds its request unchanged. The memory side moves whole lines: it has a request, a write flag, a line address, write data and read data, and the memory answers with a ready flag. The victim buffer uses FIFO replacement. A dirty line pushed out of the buffer is written back to memory before its slot is reused. A clean line pushed out is simply dropped.

The default geometry has 256 lines of four 32-bit words each and 4 victim entries. The CPU address is 14 bits wide and addresses words. Bits [1:0] select the word within the line, bits [9:2] select the primary slot, and bits [13:10] form the tag. The line address sent to memory is the CPU address bits [13:2].

Top module: `cvb_cache`

## Requirements
- R1: After reset every line in both structures is invalid, and the block shows cpu_hit=0, cpu_stall=0 and mem_req=0 while no access is presented; the first access to any line stalls and reads that line from memory.
- R2: A read that hits the primary array completes in its first cycle: cpu_hit=1, cpu_stall=0, no memory request, and cpu_rdata is the word selected by address bits [1:0].
- R3: A write that hits the primary array completes in its first cycle, replaces only the addressed word and marks the line dirty; later reads return the new word.
- R4: When an access misses in both structures, the block issues a memory read (mem_we=0) of line address cpu_addr[13:2]. The line is installed in the primary array, and the access completes as a hit in the cycle after the cycle in which mem_ready is seen.
- R5: A valid line displaced from the primary array enters the victim buffer without a memory write. Only lines displaced from the primary array ever enter the buffer.
- R6: An access that misses in the primary array and hits in the victim buffer makes no memory request and stalls for exactly two cycles, the lookup cycle and the swap cycle. It completes on the third cycle. The line it displaced takes the vacated buffer entry.
- R7: The victim buffer has 4 entries with FIFO replacement. The fifth insertion into a full buffer pushes out the oldest inserted line, and a later access to that line goes to memory.
- R8: A dirty line pushed out of the victim buffer is written to memory (mem_we=1, its own line address, its full data) before the fill read of the same miss. A clean line that is pushed out causes no memory write.
- R9: Once raised, mem_req stays high with unchanged mem_addr and mem_we until mem_ready is seen.
- R10: A line is held in at most one place at a time, either the primary array or one victim entry. An access that hits the primary array never also matches the victim buffer.
- R11: Dirty state and written data follow a line through swaps. A line written in the primary array, moved to the buffer, swapped back and out again, and finally pushed out, is written back with the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_addr | input | 14 | Word address: [13:10] tag, [9:2] slot, [1:0] word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when cpu_hit is high |
| cpu_hit | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Access is not yet complete; hold the request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 means line write-back, 0 means line fetch |
| mem_addr | output | 12 | Line address |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Fetched line, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the transfer this cycle |

## Verification
The assertions assume three things about the inputs. The CPU keeps cpu_addr, cpu_wdata and its strobe steady for as long as cpu_stall is high. At most one strobe is high at a time. The memory eventually raises mem_ready while mem_req is high. The swap-then-hit and fill-then-hit properties rely on the held request. The bench access task holds the request until it sees cpu_hit and drops the strobe only after that edge. The memory model raises ready only while a request is pending, after a fixed latency. The address sweeps repeatedly push several tags onto one slot so that the FIFO and write-back paths are exercised.

// File: rtl/cvb_pkg.sv
package cvb_pkg;
    localparam int ADDR_W     = 14;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int LINES      = 256;
    localparam int VB_ENTRIES = 4;

    localparam int WOFF_W  = $clog2(LINE_WORDS);
    localparam int INDEX_W = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - INDEX_W - WOFF_W;
    localparam int LADDR_W = ADDR_W - WOFF_W;
    localparam int LINE_W  = WORD_W * LINE_WORDS;
    localparam int VB_IDX_W = $clog2(VB_ENTRIES);

    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_SWAP,
        ST_WBACK,
        ST_FILL
    } cvb_state_e;

    typedef struct packed {
        logic               valid;
        logic               dirty;
        logic [LADDR_W-1:0] laddr;
        logic [LINE_W-1:0]  data;
    } vline_t;

    typedef struct packed {
        cvb_state_e          st;
        logic [VB_IDX_W-1:0] ptr;
    } ctl_t;
endpackage

// File: rtl/cvb_main_array.sv
module cvb_main_array
    import cvb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [LINE_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [LINE_W-1:0]  wr_data
);
    logic [LINES-1:0] valid_q, valid_d;
    logic             dirty_q [LINES];
    logic [TAG_W-1:0] tag_q   [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) begin
            valid_d[wr_idx] = wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            dirty_q[wr_idx] <= wr_dirty;
            tag_q[wr_idx]   <= wr_tag;
            data_q[wr_idx]  <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/cvb_victim_buf.sv
module cvb_victim_buf
    import cvb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LADDR_W-1:0]  look_laddr,
    output logic                look_hit,
    output logic [VB_IDX_W-1:0] look_idx,
    output vline_t              look_line,
    input  logic [VB_IDX_W-1:0] rd_idx,
    output vline_t              rd_line,
    input  logic                wr_en,
    input  logic [VB_IDX_W-1:0] wr_idx,
    input  vline_t              wr_line
);
    vline_t ent_q [VB_ENTRIES];
    vline_t ent_d [VB_ENTRIES];
    logic [VB_ENTRIES-1:0] match;

    for (genvar g = 0; g < VB_ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_q[g].valid && (ent_q[g].laddr == look_laddr);
    end

    always_comb begin
        look_idx = '0;
        for (int i = VB_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                look_idx = VB_IDX_W'(i);
            end
        end
    end

    assign look_hit  = |match;
    assign look_line = ent_q[look_idx];
    assign rd_line   = ent_q[rd_idx];

    always_comb begin
        for (int i = 0; i < VB_ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < VB_ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < VB_ENTRIES; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    // R10
    vb_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match))
        else $error("victim buffer holds one line twice");
endmodule

// File: rtl/cvb_cache.sv
module cvb_cache
    import cvb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [13:0]        cpu_addr,
    input  logic [31:0]        cpu_wdata,
    output logic [31:0]        cpu_rdata,
    output logic               cpu_hit,
    output logic               cpu_stall,
    output logic               mem_req,
    output logic               mem_we,
    output logic [11:0]        mem_addr,
    output logic [127:0]       mem_wdata,
    input  logic [127:0]       mem_rdata,
    input  logic               mem_ready
);
    ctl_t ctl_q, ctl_d;

    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic [WOFF_W-1:0]  req_woff;
    logic [LADDR_W-1:0] req_laddr;
    logic               access;

    assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx   = cpu_addr[WOFF_W +: INDEX_W];
    assign req_woff  = cpu_addr[WOFF_W-1:0];
    assign req_laddr = cpu_addr[ADDR_W-1:WOFF_W];
    assign access    = cpu_rd | cpu_wr;

    logic               ma_rd_valid, ma_rd_dirty;
    logic [TAG_W-1:0]   ma_rd_tag;
    logic [LINE_W-1:0]  ma_rd_data;
    logic               ma_wr_en, ma_wr_valid, ma_wr_dirty;
    logic [TAG_W-1:0]   ma_wr_tag;
    logic [LINE_W-1:0]  ma_wr_data;
    logic               main_hit;

    cvb_main_array i_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_valid (ma_rd_valid),
        .rd_dirty (ma_rd_dirty),
        .rd_tag   (ma_rd_tag),
        .rd_data  (ma_rd_data),
        .wr_en    (ma_wr_en),
        .wr_idx   (req_idx),
        .wr_valid (ma_wr_valid),
        .wr_dirty (ma_wr_dirty),
        .wr_tag   (ma_wr_tag),
        .wr_data  (ma_wr_data)
    );

    assign main_hit = ma_rd_valid && (ma_rd_tag == req_tag);

    logic                vb_hit;
    logic [VB_IDX_W-1:0] vb_hit_idx;
    vline_t              vb_hit_line, vb_head, vb_wr_line, evict_line;
    logic                vb_wr_en;
    logic [VB_IDX_W-1:0] vb_wr_idx;

    cvb_victim_buf i_vbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_laddr (req_laddr),
        .look_hit   (vb_hit),
        .look_idx   (vb_hit_idx),
        .look_line  (vb_hit_line),
        .rd_idx     (ctl_q.ptr),
        .rd_line    (vb_head),
        .wr_en      (vb_wr_en),
        .wr_idx     (vb_wr_idx),
        .wr_line    (vb_wr_line)
    );

    always_comb begin
        evict_line.valid = ma_rd_valid;
        evict_line.dirty = ma_rd_dirty;
        evict_line.laddr = {ma_rd_tag, req_idx};
        evict_line.data  = ma_rd_data;
    end

    assign cpu_rdata = ma_rd_data[req_woff*WORD_W +: WORD_W];

    always_comb begin
        ctl_d       = ctl_q;
        cpu_hit     = 1'b0;
        cpu_stall   = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = req_laddr;
        mem_wdata   = vb_head.data;
        ma_wr_en    = 1'b0;
        ma_wr_valid = 1'b1;
        ma_wr_dirty = 1'b0;
        ma_wr_tag   = req_tag;
        ma_wr_data  = ma_rd_data;
        vb_wr_en    = 1'b0;
        vb_wr_idx   = ctl_q.ptr;
        vb_wr_line  = evict_line;
        case (ctl_q.st)
            ST_LOOKUP: begin
                if (access) begin
                    if (main_hit) begin
                        cpu_hit = 1'b1;
                        if (cpu_wr) begin
                            ma_wr_en    = 1'b1;
                            ma_wr_dirty = 1'b1;
                            ma_wr_data[req_woff*WORD_W +: WORD_W] = cpu_wdata;
                        end
                    end else begin
                        cpu_stall = 1'b1;
                        if (vb_hit) begin
                            ctl_d.st = ST_SWAP;
                        end else if (ma_rd_valid && vb_head.valid && vb_head.dirty) begin
                            ctl_d.st = ST_WBACK;
                        end else begin
                            ctl_d.st = ST_FILL;
                        end
                    end
                end
            end
            ST_SWAP: begin
                cpu_stall = 1'b1;
                if (vb_hit) begin
                    ma_wr_en    = 1'b1;
                    ma_wr_dirty = vb_hit_line.dirty;
                    ma_wr_data  = vb_hit_line.data;
                    vb_wr_en    = 1'b1;
                    vb_wr_idx   = vb_hit_idx;
                end
                ctl_d.st = ST_LOOKUP;
            end
            ST_WBACK: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = vb_head.laddr;
                if (mem_ready) begin
                    vb_wr_en         = 1'b1;
                    vb_wr_line       = vb_head;
                    vb_wr_line.valid = 1'b0;
                    ctl_d.st         = ST_FILL;
                end
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                if (mem_ready) begin
                    ma_wr_en   = 1'b1;
                    ma_wr_data = mem_rdata;
                    if (ma_rd_valid) begin
                        vb_wr_en  = 1'b1;
                        ctl_d.ptr = ctl_q.ptr + 1'b1;
                    end
                    ctl_d.st = ST_LOOKUP;
                end
            end
            default: ctl_d.st = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_LOOKUP, ptr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
        else $error("memory request dropped or changed before ready");

    // R6
    swap_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SWAP) |=> (cpu_hit && !mem_req))
        else $error("swap not followed by a hit");

    // R4
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FILL && mem_ready) |=> cpu_hit)
        else $error("fill not followed by a hit");

    // R10
    excl_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && main_hit) |-> !vb_hit)
        else $error("line present in both primary array and victim buffer");

    // R8
    wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (vb_head.valid && vb_head.dirty))
        else $error("write-back of a clean or empty victim entry");
endmodule

// File: tb/test_cvb_cache.sv
module test_cvb_cache;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [13:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_hit, cpu_stall;
    logic         mem_req, mem_we, mem_ready;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata;

    int errors = 0;
    int checks = 0;

    cvb_cache i_cvb_cache (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model
    logic [127:0] mem_store [int];
    logic [31:0]  shadow [int];
    int rd_cnt = 0, wb_cnt = 0, hs_viol = 0, lat_cnt = 0;
    logic [11:0]  last_wb_addr = '0;
    logic [127:0] last_wb_data = '0;
    logic         prev_wait = 1'b0, prev_we = 1'b0;
    logic [11:0]  prev_addr = '0;

    function automatic logic [31:0] pat(input int laddr, input int w);
        return 32'h5A00_0000 | 32'(laddr << 2) | 32'(w);
    endfunction

    function automatic logic [127:0] mem_line(input int laddr);
        logic [127:0] l;
        if (mem_store.exists(laddr)) return mem_store[laddr];
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = pat(laddr, w);
        return l;
    endfunction

    function automatic logic [31:0] exp_word(input int a);
        if (shadow.exists(a)) return shadow[a];
        return pat(a >> 2, a & 3);
    endfunction

    assign mem_ready = mem_req && (lat_cnt == MEM_LAT);
    always_comb mem_rdata = mem_line(int'(mem_addr));

    always @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt   <= 0;
            prev_wait <= 1'b0;
        end else begin
            if (prev_wait && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
                hs_viol++;
            prev_wait <= mem_req && !mem_ready;
            prev_addr <= mem_addr;
            prev_we   <= mem_we;
            if (mem_req && !mem_ready) lat_cnt <= lat_cnt + 1;
            else lat_cnt <= 0;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem_store[int'(mem_addr)] = mem_wdata;
                    wb_cnt++;
                    last_wb_addr = mem_addr;
                    last_wb_data = mem_wdata;
                end else begin
                    rd_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] adr(input int t, input int idx, input int w);
        return {t[3:0], idx[7:0], w[1:0]};
    endfunction

    task automatic access(input bit wr, input logic [13:0] a, input logic [31:0] d,
                          output int cyc, output logic [31:0] rd);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = !wr; cpu_wr = wr;
        cyc = 0;
        #1;
        while (!cpu_hit && cyc < 1000) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        if (wr) shadow[int'(a)] = d;
    endtask

    task automatic rd_chk(input logic [13:0] a, input string req, input int exp_cyc, output int cyc);
        logic [31:0] rd;
        access(1'b0, a, '0, cyc, rd);
        chk(rd == exp_word(int'(a)), req, rd, exp_word(int'(a)));
        if (exp_cyc >= 0) chk(cyc == exp_cyc, req, cyc, exp_cyc);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc, r0, w0;
        logic [31:0] rd;
        logic [31:0] xval = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(!cpu_hit && !cpu_stall && !mem_req, "R1 idle after reset", {cpu_hit, cpu_stall, mem_req}, 0);

        // R1 R4 first access goes to memory
        r0 = rd_cnt;
        rd_chk(adr(0,1,0), "R4 cold read data", -1, cyc);
        chk(rd_cnt == r0 + 1, "R1 cold miss reads memory", rd_cnt, r0 + 1);
        chk(cyc > 0, "R1 cold miss stalls", cyc, 1);
        // R2 hit
        rd_chk(adr(0,1,1), "R2 read hit", 0, cyc);
        chk(rd_cnt == r0 + 1, "R2 hit no memory", rd_cnt, r0 + 1);
        // R3 write hit
        access(1'b1, adr(0,1,2), xval, cyc, rd);
        chk(cyc == 0, "R3 write hit no stall", cyc, 0);
        rd_chk(adr(0,1,2), "R3 write visible", 0, cyc);
        rd_chk(adr(0,1,3), "R3 other word kept", 0, cyc);

        // R5 conflict miss moves dirty line to buffer without write
        w0 = wb_cnt;
        rd_chk(adr(1,1,0), "R4 conflict fill", -1, cyc);
        chk(rd_cnt == r0 + 2, "R4 conflict reads memory", rd_cnt, r0 + 2);
        chk(wb_cnt == w0, "R5 eviction into buffer no write", wb_cnt, w0);
        // R6 victim hits, R11 data retained
        r0 = rd_cnt;
        rd_chk(adr(0,1,2), "R6 R11 victim hit data", 2, cyc);
        chk(rd_cnt == r0, "R6 victim hit no memory", rd_cnt, r0);
        rd_chk(adr(1,1,1), "R6 displaced line swapped back", 2, cyc);
        // R10 line now in primary only: immediate hit
        rd_chk(adr(1,1,2), "R10 swapped line hits in primary", 0, cyc);

        // R7 fill FIFO: A1,A2,A3 enter; A4 pushes dirty A0 out
        rd_chk(adr(2,1,0), "R7 fill t2", -1, cyc);
        rd_chk(adr(3,1,0), "R7 fill t3", -1, cyc);
        rd_chk(adr(4,1,0), "R7 fill t4", -1, cyc);
        chk(wb_cnt == w0, "R8 no write before buffer full", wb_cnt, w0);
        rd_chk(adr(5,1,0), "R7 fill t5", -1, cyc);
        chk(wb_cnt == w0 + 1, "R8 dirty push-out written", wb_cnt, w0 + 1);
        chk(last_wb_addr == {4'd0, 8'd1}, "R8 write-back address", last_wb_addr, {4'd0, 8'd1});
        chk(last_wb_data[64 +: 32] == xval, "R11 write-back carries written word",
            last_wb_data[64 +: 32], xval);
        // R7 oldest line gone: memory access; A1 clean pushed out, no write
        r0 = rd_cnt;
        rd_chk(adr(0,1,2), "R7 pushed-out line refetched", -1, cyc);
        chk(rd_cnt == r0 + 1, "R7 pushed-out line from memory", rd_cnt, r0 + 1);
        chk(wb_cnt == w0 + 1, "R8 clean push-out not written", wb_cnt, w0 + 1);
        rd_chk(adr(2,1,3), "R6 older entry still buffered", 2, cyc);
        rd_chk(adr(3,1,1), "R6 second buffered entry", 2, cyc);
        rd_chk(adr(1,1,0), "R7 line t1 left the buffer", -1, cyc);
        chk(rd_cnt == r0 + 2, "R7 line t1 from memory", rd_cnt, r0 + 2);

        // sweep: many slots, all words, reads then writes
        for (int idx = 16; idx < 48; idx++) begin
            for (int w = 0; w < 4; w++) begin
                rd_chk(adr(6, idx, w), (w == 0) ? "R4 sweep miss" : "R2 sweep hit",
                       (w == 0) ? -1 : 0, cyc);
            end
            for (int w = 0; w < 4; w++) begin
                access(1'b1, adr(6, idx, w), 32'(idx * 16 + w) ^ 32'h1234_0000, cyc, rd);
                chk(cyc == 0, "R3 sweep write hit", cyc, 0);
            end
        end
        // conflict sweep: a second tag on each slot, then back via the buffer
        for (int idx = 16; idx < 48; idx++) begin
            rd_chk(adr(7, idx, 1), "R4 sweep conflict", -1, cyc);
            rd_chk(adr(6, idx, 3), "R6 R11 sweep swap back", 2, cyc);
        end
        // written data returns from memory after many push-outs
        for (int idx = 16; idx < 48; idx++) begin
            rd_chk(adr(8, idx, 0), "R4 sweep third tag", -1, cyc);
        end
        for (int idx = 16; idx < 48; idx += 5) begin
            for (int w = 0; w < 4; w++)
                rd_chk(adr(6, idx, w), "R8 R11 written data survives", -1, cyc);
        end

        chk(hs_viol == 0, "R9 request held until ready", hs_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule